// File: doc/BRIEF.md
# Transport Stream Port with Packet Time Stamps

This block connects a byte-wide transport stream device to a packet buffer. It works in one of two directions. In capture mode it takes 8-bit stream bytes qualified by valid and sync strobes. It counts each source packet to its configured length and passes the bytes on toward the buffer. Every packet is tagged with the cycle-timer value seen at its sync byte. A serial copy-control byte, shifted in during a fixed window after sync, is attached to the packet as well. Stamp and copy-control byte are handed over as sideband fields together with the last byte of the packet.

In playback mode the block takes packets from the buffer over a valid/ready interface, where the first byte of each packet carries its stored stamp. It holds the packet until the low bits of the cycle timer equal that stamp. It then drives the bytes toward the stream device with a regenerated stream clock, valid and sync. The stream clock runs at one of two rates, the slower being half the faster.

A direction-select output tells external bus switches which way the byte lanes point. Bus serialization, error coding and the buffer memory itself lie outside this block.

Top module: `tsport_stamp`

## Requirements
- R1: `dir_sel` is 0 while `dir_play` is 0 (capture) and 1 while `dir_play` is 1 (playback).
- R2: In capture mode a byte with `ts_valid` and `ts_sync` both high opens a packet. That byte and every later valid byte of the packet appear on `cap_data` with `cap_valid` high one clock later.
- R3: `cap_last` rises with the 188th byte of a packet when `pkt_short` is 0 and with the 130th byte when it is 1. At that point `cap_stamp` equals the value of `cyc_time` in the clock of the packet's sync byte.
- R4: `ts_cp` is sampled in the sync clock and in the 7 clocks that follow it, and in no others. The first bit sampled lands in bit 7 of `cap_cpinfo`, which is valid while `cap_last` is high.
- R5: A sync byte arriving before the open packet is complete aborts that packet with no `cap_last`. `cap_err` pulses for one clock, together with the new sync byte on `cap_data`, and the new packet is counted from that byte.
- R6: Valid bytes that arrive while no packet is open produce no `cap_valid`.
- R7: In playback mode no byte of a packet is driven before `cyc_time` equals the stamp offered with the packet's first byte. The first byte follows within ten clocks of the match.
- R8: `out_clk` runs with a half period of FAST_HALF clocks when `rate_slow` is 0 and 2*FAST_HALF clocks when it is 1. `out_data` changes only together with a falling edge of `out_clk`.
- R9: A played packet is exactly the configured length, in buffer order, one byte per `out_clk` period. `out_sync` is high only with the first byte, and `out_sync` implies `out_valid`.
- R10: A buffer byte offered without `pb_first` while no packet is pending is accepted and dropped. It never appears on `out_data`.
- R11: After reset `cap_valid`, `cap_last`, `cap_err`, `out_valid`, `out_sync`, `out_clk` and `pb_ready` are all low.
- R12: In capture mode `out_clk` stays low. In playback mode `cap_valid` stays low whatever the stream inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the capture stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_play | input | 1 | 0 capture from stream, 1 playback to stream |
| pkt_short | input | 1 | 0 selects 188-byte packets, 1 selects 130-byte packets |
| rate_slow | input | 1 | Selects the half-rate playback stream clock |
| cyc_time | input | 25 | Low bits of the free-running cycle timer |
| ts_data | input | 8 | Capture stream byte |
| ts_valid | input | 1 | Capture byte qualifier, active high |
| ts_sync | input | 1 | Marks the leading byte of a packet, active high |
| ts_cp | input | 1 | Serial copy-control bit stream |
| cap_data | output | 8 | Captured byte toward the buffer |
| cap_valid | output | 1 | `cap_data` holds a packet byte |
| cap_last | output | 1 | Final byte of a complete packet |
| cap_err | output | 1 | One-clock pulse on a packet aborted by early sync |
| cap_stamp | output | 25 | Time stamp of the packet, valid with `cap_last` |
| cap_cpinfo | output | 8 | Copy-control byte, valid with `cap_last` |
| pb_data | input | 8 | Buffer byte for playback |
| pb_valid | input | 1 | Buffer offers a byte |
| pb_first | input | 1 | Offered byte is the first of a packet |
| pb_stamp | input | 25 | Release stamp, meaningful with `pb_first` |
| pb_ready | output | 1 | Offered byte is taken this clock |
| out_clk | output | 1 | Regenerated playback stream clock |
| out_data | output | 8 | Playback stream byte |
| out_valid | output | 1 | Playback byte qualifier |
| out_sync | output | 1 | Playback leading-byte marker |
| dir_sel | output | 1 | Direction select for external lane switches |

## Verification
Several relations are checked on every clock: playback data only moves on a falling stream clock, sync never appears without valid, a completed packet never carries an error flag, the buffer is never popped without an offer, and each direction keeps the other one quiet. Packet lengths, stamp values, the exact copy-control window and the release delay after a stamp match depend on whole sequences. Only the bench scenarios can show these, by counting bytes and comparing sideband fields against values computed from the timer it drives.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  localparam int CP_BITS = 8;

  typedef enum logic [1:0] {
    PB_IDLE,
    PB_WAIT,
    PB_SEND
  } pb_state_t;

endpackage

// File: rtl/tsp_clkgen.sv
module tsp_clkgen #(
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic sclk,
  output logic tick
);
  localparam int CW = $clog2(2 * FAST_HALF + 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_HALF - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(2 * FAST_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          sclk_q, sclk_d;
  logic          wrap;

  assign lim  = slow ? LIM_SLOW : LIM_FAST;
  assign wrap = (cnt_q >= lim);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // byte slot: the edge that takes the stream clock low
  assign tick = run && wrap && sclk_q;
  assign sclk = sclk_q;
endmodule

// File: rtl/tsp_capture.sv
module tsp_capture #(
  parameter int LEN_LONG  = 188,
  parameter int LEN_SHORT = 130,
  parameter int STAMP_W   = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               short_pkt,
  input  logic [STAMP_W-1:0] timer,
  input  logic [7:0]         ts_data,
  input  logic               ts_valid,
  input  logic               ts_sync,
  input  logic               ts_cp,
  output logic [7:0]         cap_data,
  output logic               cap_valid,
  output logic               cap_last,
  output logic               cap_err,
  output logic [STAMP_W-1:0] cap_stamp,
  output logic [7:0]         cap_cpinfo
);
  import tsp_pkg::*;
  localparam int CW = $clog2(LEN_LONG + 1);

  logic [CW-1:0]      cnt_q, cnt_d, len_m1;
  logic [3:0]         win_q, win_d;
  logic [7:0]         info_q, info_d, data_q, data_d;
  logic [STAMP_W-1:0] stamp_q, stamp_d;
  logic               vld_q, vld_d, last_q, last_d, err_q, err_d;

  assign len_m1 = short_pkt ? CW'(LEN_SHORT - 1) : CW'(LEN_LONG - 1);

  always_comb begin
    cnt_d   = cnt_q;
    win_d   = win_q;
    info_d  = info_q;
    stamp_d = stamp_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    last_d  = 1'b0;
    err_d   = 1'b0;
    if (!en) begin
      cnt_d = '0;
      win_d = '0;
    end else begin
      if (win_q != '0) begin
        info_d = {info_q[6:0], ts_cp};
        win_d  = win_q - 1'b1;
      end
      if (ts_valid && ts_sync) begin
        err_d   = (cnt_q != '0);
        cnt_d   = CW'(1);
        stamp_d = timer;
        win_d   = 4'(CP_BITS - 1);
        info_d  = {info_q[6:0], ts_cp};
        vld_d   = 1'b1;
        data_d  = ts_data;
      end else if (ts_valid && cnt_q != '0) begin
        vld_d  = 1'b1;
        data_d = ts_data;
        if (cnt_q == len_m1) begin
          last_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d  = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      win_q   <= '0;
      info_q  <= '0;
      stamp_q <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      win_q   <= win_d;
      info_q  <= info_d;
      stamp_q <= stamp_d;
      data_q  <= data_d;
      vld_q   <= vld_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end

  assign cap_data   = data_q;
  assign cap_valid  = vld_q;
  assign cap_last   = last_q;
  assign cap_err    = err_q;
  assign cap_stamp  = stamp_q;
  assign cap_cpinfo = info_q;
endmodule

// File: rtl/tsp_playback.sv
module tsp_playback #(
  parameter int LEN_LONG  = 188,
  parameter int LEN_SHORT = 130,
  parameter int STAMP_W   = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               short_pkt,
  input  logic [STAMP_W-1:0] timer,
  input  logic               tick,
  input  logic [7:0]         pb_data,
  input  logic               pb_valid,
  input  logic               pb_first,
  input  logic [STAMP_W-1:0] pb_stamp,
  output logic               pb_ready,
  output logic [7:0]         out_data,
  output logic               out_valid,
  output logic               out_sync
);
  import tsp_pkg::*;
  localparam int CW = $clog2(LEN_LONG + 1);

  pb_state_t          st_q, st_d;
  logic [CW-1:0]      idx_q, idx_d, len_m1;
  logic [STAMP_W-1:0] stamp_q, stamp_d;
  logic [7:0]         od_q, od_d;
  logic               ov_q, ov_d, os_q, os_d;

  assign len_m1 = short_pkt ? CW'(LEN_SHORT - 1) : CW'(LEN_LONG - 1);

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    stamp_d  = stamp_q;
    od_d     = od_q;
    ov_d     = ov_q;
    os_d     = os_q;
    pb_ready = 1'b0;
    case (st_q)
      PB_IDLE: if (pb_valid) begin
        if (pb_first) begin
          stamp_d = pb_stamp;
          st_d    = PB_WAIT;
        end else begin
          pb_ready = 1'b1;
        end
      end
      PB_WAIT: if (timer == stamp_q) st_d = PB_SEND;
      default: ;
    endcase
    if (tick) begin
      ov_d = 1'b0;
      os_d = 1'b0;
      if (st_q == PB_SEND && pb_valid) begin
        pb_ready = 1'b1;
        ov_d     = 1'b1;
        os_d     = (idx_q == '0);
        od_d     = pb_data;
        if (idx_q == len_m1) begin
          idx_d = '0;
          st_d  = PB_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
    if (!en) begin
      st_d     = PB_IDLE;
      idx_d    = '0;
      ov_d     = 1'b0;
      os_d     = 1'b0;
      pb_ready = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PB_IDLE;
      idx_q   <= '0;
      stamp_q <= '0;
      od_q    <= '0;
      ov_q    <= 1'b0;
      os_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      stamp_q <= stamp_d;
      od_q    <= od_d;
      ov_q    <= ov_d;
      os_q    <= os_d;
    end
  end

  assign out_data  = od_q;
  assign out_valid = ov_q;
  assign out_sync  = os_q;
endmodule

// File: rtl/tsport_stamp.sv
module tsport_stamp #(
  parameter int LEN_LONG  = 188,
  parameter int LEN_SHORT = 130,
  parameter int STAMP_W   = 25,
  parameter int FAST_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_play,
  input  logic               pkt_short,
  input  logic               rate_slow,
  input  logic [STAMP_W-1:0] cyc_time,
  input  logic [7:0]         ts_data,
  input  logic               ts_valid,
  input  logic               ts_sync,
  input  logic               ts_cp,
  output logic [7:0]         cap_data,
  output logic               cap_valid,
  output logic               cap_last,
  output logic               cap_err,
  output logic [STAMP_W-1:0] cap_stamp,
  output logic [7:0]         cap_cpinfo,
  input  logic [7:0]         pb_data,
  input  logic               pb_valid,
  input  logic               pb_first,
  input  logic [STAMP_W-1:0] pb_stamp,
  output logic               pb_ready,
  output logic               out_clk,
  output logic [7:0]         out_data,
  output logic               out_valid,
  output logic               out_sync,
  output logic               dir_sel
);
  logic slot_tick;

  assign dir_sel = dir_play;

  tsp_clkgen #(.FAST_HALF(FAST_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(dir_play), .slow(rate_slow),
    .sclk(out_clk), .tick(slot_tick)
  );

  tsp_capture #(.LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT), .STAMP_W(STAMP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(!dir_play), .short_pkt(pkt_short),
    .timer(cyc_time), .ts_data(ts_data), .ts_valid(ts_valid),
    .ts_sync(ts_sync), .ts_cp(ts_cp), .cap_data(cap_data),
    .cap_valid(cap_valid), .cap_last(cap_last), .cap_err(cap_err),
    .cap_stamp(cap_stamp), .cap_cpinfo(cap_cpinfo)
  );

  tsp_playback #(.LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT), .STAMP_W(STAMP_W)) u_pb (
    .clk(clk), .rst_n(rst_n), .en(dir_play), .short_pkt(pkt_short),
    .timer(cyc_time), .tick(slot_tick), .pb_data(pb_data),
    .pb_valid(pb_valid), .pb_first(pb_first), .pb_stamp(pb_stamp),
    .pb_ready(pb_ready), .out_data(out_data), .out_valid(out_valid),
    .out_sync(out_sync)
  );
endmodule

// File: rtl/tsport_stamp_chk.sv
module tsport_stamp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_play,
  input logic       out_clk,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_sync,
  input logic       cap_valid,
  input logic       cap_last,
  input logic       cap_err,
  input logic       pb_valid,
  input logic       pb_ready
);
  // R8
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(out_clk) && !out_clk) |-> $stable(out_data));

  // R9
  sync_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_valid);

  // R3
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |-> cap_valid);

  // R5
  err_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_err |-> !cap_last);

  // R10
  pop_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_ready |-> pb_valid);

  // R12
  capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_play && $past(dir_play)) |-> !cap_valid);

  // R12
  clock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_play && $past(!dir_play)) |-> !out_clk);
endmodule

bind tsport_stamp tsport_stamp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_play(dir_play), .out_clk(out_clk),
  .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync),
  .cap_valid(cap_valid), .cap_last(cap_last), .cap_err(cap_err),
  .pb_valid(pb_valid), .pb_ready(pb_ready)
);

// File: tb/sim_tsport_stamp.sv
module sim_tsport_stamp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dir_play, pkt_short, rate_slow;
  logic [24:0] cyc_time;
  logic [7:0]  ts_data;
  logic        ts_valid, ts_sync, ts_cp;
  logic [7:0]  cap_data;
  logic        cap_valid, cap_last, cap_err;
  logic [24:0] cap_stamp;
  logic [7:0]  cap_cpinfo;
  logic [7:0]  pb_data;
  logic        pb_valid, pb_first;
  logic [24:0] pb_stamp;
  logic        pb_ready, out_clk;
  logic [7:0]  out_data;
  logic        out_valid, out_sync, dir_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  tsport_stamp u0 (.*);

  always #4 clk = ~clk;

  // cycle timer: advances just after each rising edge
  initial begin
    cyc_time = 25'h1FFF_F00;
    forever begin
      @(posedge clk);
      #1 cyc_time = cyc_time + 1'b1;
    end
  end

  // playback observer
  logic [7:0]  rx_data [0:255];
  int          rx_n = 0, rx_syncs = 0, sync_at = -1, cap_bad = 0, clk_bad = 0;
  logic [24:0] first_t;
  logic        prev_clk = 1'b0, prev_dir = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (!prev_clk && out_clk && out_valid) begin
        if (rx_n == 0) first_t = cyc_time;
        if (out_sync) begin rx_syncs++; sync_at = rx_n; end
        if (rx_n < 256) rx_data[rx_n] = out_data;
        rx_n++;
      end
      if (rst_n && dir_play && prev_dir && cap_valid) cap_bad++;
      if (rst_n && !dir_play && !prev_dir && out_clk) clk_bad++;
      prev_clk = out_clk;
      prev_dir = dir_play;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic idle_inputs();
    ts_valid = 0; ts_sync = 0; ts_cp = 0; ts_data = 0;
    pb_valid = 0; pb_first = 0; pb_data = 0; pb_stamp = 0;
  endtask

  task automatic t_reset();
    dir_play = 0; pkt_short = 0; rate_slow = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cap_valid && !cap_last && !cap_err, "R11 capture flags", {cap_valid, cap_last, cap_err}, 0);
    chk(!out_valid && !out_sync && !out_clk, "R11 playback flags", {out_valid, out_sync, out_clk}, 0);
    chk(!pb_ready, "R11 pb_ready", pb_ready, 0);
    chk(dir_sel == 1'b0, "R1 dir_sel in capture", dir_sel, 0);
  endtask

  // sends n bytes starting with a sync byte; samples one clock after each
  task automatic send_pkt(input int n, input logic [7:0] base, input logic [7:0] cp,
                          output int bad, output int last_at, output bit err0,
                          output logic [24:0] st_exp, output logic [24:0] st_got,
                          output logic [7:0] info_got);
    bad = 0; last_at = -1; err0 = 0; st_got = '0; info_got = '0; st_exp = '0;
    for (int i = 0; i < n; i++) begin
      ts_valid = 1; ts_sync = (i == 0); ts_data = base + 8'(i);
      ts_cp = (i < 8) ? cp[7 - i] : ~cp[0];
      if (i == 0) st_exp = cyc_time;
      @(negedge clk);
      if (cap_valid !== 1'b1 || cap_data !== base + 8'(i)) bad++;
      if (i == 0) err0 = cap_err;
      else if (cap_err) bad++;
      if (cap_last) begin last_at = i; st_got = cap_stamp; info_got = cap_cpinfo; end
    end
  endtask

  task automatic t_capture(input bit short_sel, input logic [7:0] cp);
    int bad, last_at, len;
    bit e0;
    logic [24:0] se, sg;
    logic [7:0]  ig;
    len = short_sel ? 130 : 188;
    pkt_short = short_sel; dir_play = 0;
    idle_inputs();
    // stray bytes with no packet open
    ts_valid = 1; ts_data = 8'h11;
    @(negedge clk);
    @(negedge clk);
    chk(!cap_valid, "R6 stray byte ignored", cap_valid, 0);
    send_pkt(len, 8'h20, cp, bad, last_at, e0, se, sg, ig);
    idle_inputs();
    chk(bad == 0, "R2 captured bytes", bad, 0);
    chk(last_at == len - 1, "R3 last position", last_at, len - 1);
    chk(sg == se, "R3 stamp at sync", sg, se);
    chk(ig == cp, "R4 copy-control byte", ig, cp);
    @(negedge clk);
    chk(!cap_valid && !cap_last, "R2 quiet after packet", {cap_valid, cap_last}, 0);
  endtask

  task automatic t_abort();
    int bad, last_at;
    bit e0;
    logic [24:0] se, sg;
    logic [7:0]  ig;
    pkt_short = 1; dir_play = 0;
    send_pkt(10, 8'h40, 8'h0F, bad, last_at, e0, se, sg, ig);
    chk(last_at == -1 && bad == 0, "R5 no last on aborted packet", last_at, -1);
    send_pkt(130, 8'h80, 8'hC3, bad, last_at, e0, se, sg, ig);
    idle_inputs();
    chk(e0 == 1'b1, "R5 error pulse with new sync", e0, 1);
    chk(last_at == 129 && bad == 0, "R5 new packet counted from sync", last_at, 129);
    chk(sg == se && ig == 8'hC3, "R5 new packet stamp", sg, se);
    @(negedge clk);
    chk(!cap_err, "R5 error is one clock", cap_err, 0);
  endtask

  task automatic t_rate(input bit slow);
    int hi, lo, exp;
    dir_play = 1; rate_slow = slow;
    exp = slow ? 4 : 2;
    repeat (20) @(negedge clk);
    while (out_clk) @(negedge clk);
    while (!out_clk) @(negedge clk);
    hi = 0; while (out_clk)  begin hi++; @(negedge clk); end
    lo = 0; while (!out_clk) begin lo++; @(negedge clk); end
    chk(hi == exp && lo == exp, slow ? "R8 slow half period" : "R8 fast half period", {hi[15:0], lo[15:0]}, {exp[15:0], exp[15:0]});
    chk(dir_sel == 1'b1, "R1 dir_sel in playback", dir_sel, 1);
  endtask

  task automatic t_playback();
    int idx, bad, guard;
    bit took, stray_taken;
    logic [24:0] s, d;
    dir_play = 1; pkt_short = 1; rate_slow = 0;
    idle_inputs();
    // capture-side noise while in playback
    ts_valid = 1; ts_sync = 1; ts_data = 8'h99;
    repeat (4) @(negedge clk);
    rx_n = 0; rx_syncs = 0; sync_at = -1;
    s = cyc_time + 25'd60;
    idx = -1; stray_taken = 0;
    pb_valid = 1; pb_first = 0; pb_data = 8'hEE; pb_stamp = s;
    #1 took = pb_ready;
    guard = 0;
    while (idx < 130 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (took) begin
        if (idx < 0) stray_taken = 1;
        idx++;
        if (idx >= 130) begin pb_valid = 0; pb_first = 0; end
        else begin pb_data = 8'(idx * 3 + 1); pb_first = (idx == 0); end
      end
      #1 took = pb_ready;
    end
    guard = 0;
    while (rx_n < 130 && guard < 200) begin @(negedge clk); guard++; end
    bad = 0;
    for (int i = 0; i < 130 && i < rx_n; i++) if (rx_data[i] !== 8'(i * 3 + 1)) bad++;
    d = first_t - s;
    chk(stray_taken, "R10 stray buffer byte taken", stray_taken, 1);
    chk(rx_n == 130, "R9 played length", rx_n, 130);
    chk(bad == 0, "R9 played order, R10 stray dropped", bad, 0);
    chk(rx_syncs == 1 && sync_at == 0, "R9 sync on first byte only", sync_at, 0);
    chk(d >= 1 && d <= 10, "R7 release after stamp match", d, 1);
    chk(cap_bad == 0, "R12 capture quiet in playback", cap_bad, 0);
    idle_inputs();
    dir_play = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_capture(1'b0, 8'hA5);
    t_capture(1'b1, 8'h5C);
    t_abort();
    t_rate(1'b0);
    t_rate(1'b1);
    t_playback();
    t_capture(1'b0, 8'h3E);
    chk(clk_bad == 0, "R12 stream clock quiet in capture", clk_bad, 0);
    finish_run();
  end
endmodule